// File: doc/BRIEF.md
# Power Management Control/Status Register Unit

This block holds the 16-bit power management control and status word of a storage controller function. The word sits at one offset of a small configuration read/write port. It stores three things: the device power state (full-power D0 or low-power D3hot), a wake enable bit and a wake status bit. It also returns a constant flag saying that leaving D3hot does not reset the function, so the configuration contents are kept. The block drives a wake request and three enables, for I/O decode, memory decode and interrupts. All three enables drop while the function sits in D3hot. Configuration access stays open in every state.

Two reset inputs act on the word. A full reset returns every bit to its default. A function-level reset returns only the power state and leaves the wake pair as it was. A class-mode input disables wake support when it carries code 01h. Under that code, both wake bits are forced to zero and cannot be written or set.

Top module: `pmcs_unit`

## Requirements
- R1: After a full reset, a read of the word returns 0008h, the three enables are 1 and wake_req is 0.
- R2: Bits 1:0 hold the power state (00 = D0, 11 = D3hot) and read back what was written. A write of 01 or 10 leaves the previous state unchanged.
- R3: Bit 3 always reads 1. Bits 2, 7:4 and 14:9 always read 0, and writes to them have no effect.
- R4: While class_mode is not 01h, bit 8 (wake enable) is read/write.
- R5: Bit 15 (wake status) is set by a one-cycle wake_evt pulse. Writing 1 to bit 15 clears it, and writing 0 leaves it unchanged.
- R6: When wake_evt and a write-1-to-clear of bit 15 fall in the same cycle, bit 15 stays 1.
- R7: wake_req is 1 exactly when bits 15 and 8 are both 1. It changes at the same clock edge as the register bits.
- R8: While class_mode equals 01h, bits 8 and 15 read 0 and wake_req is 0. Writes and wake events do not change them, and they are still 0 after the mode leaves 01h.
- R9: A function-level reset returns bits 1:0 to D0 and keeps bits 8 and 15. A configuration write in the same cycle is ignored.
- R10: A full reset clears bits 8 and 15 as well as the power state.
- R11: In D3hot, io_dec_en, mem_dec_en and irq_en are 0, and configuration reads still return the word. In D0 all three enables are 1.
- R12: Byte enable bit 0 gates writes to bits 7:0 and byte enable bit 1 gates writes to bits 15:8. An access at any address other than 74h writes nothing, and a read there returns 0.
- R13: Read data is registered. It appears on cfg_rdata in the cycle after cfg_rd is high, and cfg_rdata is 0 in any cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset, active high |
| flr | input | 1 | Function-level reset, synchronous, active high |
| class_mode | input | 8 | Class-code mode; 01h disables wake support |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data |
| wake_evt | input | 1 | Wake event pulse from the function |
| wake_req | output | 1 | Wake request to the platform |
| io_dec_en | output | 1 | I/O decode allowed |
| mem_dec_en | output | 1 | Memory decode allowed |
| irq_en | output | 1 | Interrupts allowed |

## Verification
Every state bit in this block is visible on the outputs. A wrong bit shows up in the read data of the very next read, and a wrong power state also shows on the three enable outputs after the same clock edge. A wrong wake pair drives wake_req wrong at that same edge, because wake_req is computed from the next-state values and not from a delayed copy of them. Faults that only show in the retained bits appear after a function-level reset pulse. Faults in the mode-01h forcing appear one edge after the mode input changes.

// File: rtl/pmcs_pkg.sv
package pmcs_pkg;
  localparam logic [1:0] PS_D0    = 2'b00;
  localparam logic [1:0] PS_D3HOT = 2'b11;

  localparam int BIT_NSR    = 3;
  localparam int BIT_WK_EN  = 8;
  localparam int BIT_WK_ST  = 15;

  function automatic logic ps_code_legal(input logic [1:0] code);
    return (code == PS_D0) || (code == PS_D3HOT);
  endfunction
endpackage

// File: rtl/pmcs_cfg_port.sv
module pmcs_cfg_port #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 16,
  parameter logic [7:0]  REG_OFFSET = 8'h74
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                blk_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic [DATA_W-1:0]   reg_image,
  output logic [DATA_W/8-1:0] lane_wr,
  output logic [DATA_W-1:0]   cfg_rdata
);
  localparam int LANES = DATA_W / 8;

  logic hit;
  assign hit = (cfg_addr == ADDR_W'(REG_OFFSET));

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_wr[g] = cfg_wr & hit & cfg_be[g] & ~blk_wr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                cfg_rdata <= '0;
    else if (cfg_rd && hit) cfg_rdata <= reg_image;
    else                    cfg_rdata <= '0;
  end

  // R13: a cycle without a read leaves the read bus at zero
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> (cfg_rdata == '0));
  // R12: no write lane fires for a foreign address
  a_r12_foreign_nowr: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr != ADDR_W'(REG_OFFSET)) |-> (lane_wr == '0));
endmodule

// File: rtl/pmcs_pstate.sv
module pmcs_pstate (
  input  logic       clk,
  input  logic       rst,
  input  logic       flr,
  input  logic       lane_wr,
  input  logic [1:0] ps_wdata,
  output logic [1:0] ps_q,
  output logic       io_dec_en,
  output logic       mem_dec_en,
  output logic       irq_en
);
  import pmcs_pkg::*;

  logic [1:0] ps_nxt;

  always_comb begin
    ps_nxt = ps_q;
    if (flr)                                    ps_nxt = PS_D0;
    else if (lane_wr && ps_code_legal(ps_wdata)) ps_nxt = ps_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q       <= PS_D0;
      io_dec_en  <= 1'b1;
      mem_dec_en <= 1'b1;
      irq_en     <= 1'b1;
    end else begin
      ps_q       <= ps_nxt;
      io_dec_en  <= (ps_nxt != PS_D3HOT);
      mem_dec_en <= (ps_nxt != PS_D3HOT);
      irq_en     <= (ps_nxt != PS_D3HOT);
    end
  end

  // R2: unlisted state codes leave the field untouched
  a_r2_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
    (lane_wr && !flr && !ps_code_legal(ps_wdata)) |=> $stable(ps_q));
  // R9: function-level reset lands in D0
  a_r9_flr_d0: assert property (@(posedge clk) disable iff (rst)
    flr |=> (ps_q == PS_D0));
  // R11: low-power state closes every gate
  a_r11_gates_shut: assert property (@(posedge clk) disable iff (rst)
    (ps_q == PS_D3HOT) |-> (!io_dec_en && !mem_dec_en && !irq_en));
endmodule

// File: rtl/pmcs_wake.sv
module pmcs_wake (
  input  logic clk,
  input  logic rst,
  input  logic wake_off,
  input  logic lane_wr,
  input  logic en_wdata,
  input  logic st_wdata,
  input  logic wake_evt,
  output logic en_q,
  output logic st_q,
  output logic wake_req
);
  logic en_nxt, st_nxt;

  always_comb begin
    en_nxt = en_q;
    st_nxt = st_q;
    if (wake_off) begin
      en_nxt = 1'b0;
      st_nxt = 1'b0;
    end else begin
      if (lane_wr) en_nxt = en_wdata;
      if (wake_evt)                  st_nxt = 1'b1;
      else if (lane_wr && st_wdata)  st_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      st_q     <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      en_q     <= en_nxt;
      st_q     <= st_nxt;
      wake_req <= en_nxt & st_nxt;
    end
  end

  // R6: an event beats a same-cycle clear
  a_r6_evt_wins: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && !wake_off) |=> st_q);
  // R8: disabled wake support forces the pair low
  a_r8_forced_low: assert property (@(posedge clk) disable iff (rst)
    wake_off |=> (!st_q && !en_q && !wake_req));
  // R5: status holds without an event or a clearing write
  a_r5_status_holds: assert property (@(posedge clk) disable iff (rst)
    (!wake_off && !wake_evt && !(lane_wr && st_wdata)) |=> (st_q == $past(st_q)));
  // R10: full reset empties the pair
  a_r10_full_clear: assert property (@(posedge clk)
    rst |=> (!st_q && !en_q && !wake_req));
endmodule

// File: rtl/pmcs_unit.sv
module pmcs_unit #(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 16,
  parameter int         MODE_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h74,
  parameter logic [7:0] WAKE_OFF   = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flr,
  input  logic [MODE_W-1:0]   class_mode,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                wake_evt,
  output logic                wake_req,
  output logic                io_dec_en,
  output logic                mem_dec_en,
  output logic                irq_en
);
  import pmcs_pkg::*;

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  lane_wr;
  logic [1:0]        ps_q;
  logic              en_q, st_q;
  logic              wake_off;
  logic [DATA_W-1:0] reg_image;

  assign wake_off = (class_mode == MODE_W'(WAKE_OFF));

  always_comb begin
    reg_image            = '0;
    reg_image[1:0]       = ps_q;
    reg_image[BIT_NSR]   = 1'b1;
    reg_image[BIT_WK_EN] = en_q;
    reg_image[BIT_WK_ST] = st_q;
  end

  pmcs_cfg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
  ) u_port (
    .clk(clk), .rst(rst), .blk_wr(flr),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_be(cfg_be),
    .reg_image(reg_image), .lane_wr(lane_wr), .cfg_rdata(cfg_rdata)
  );

  pmcs_pstate u_ps (
    .clk(clk), .rst(rst), .flr(flr),
    .lane_wr(lane_wr[0]), .ps_wdata(cfg_wdata[1:0]),
    .ps_q(ps_q), .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en), .irq_en(irq_en)
  );

  pmcs_wake u_wake (
    .clk(clk), .rst(rst), .wake_off(wake_off),
    .lane_wr(lane_wr[BIT_WK_EN/8]),
    .en_wdata(cfg_wdata[BIT_WK_EN]), .st_wdata(cfg_wdata[BIT_WK_ST]),
    .wake_evt(wake_evt),
    .en_q(en_q), .st_q(st_q), .wake_req(wake_req)
  );

  // R7: request tracks the stored pair
  a_r7_req_pair: assert property (@(posedge clk) disable iff (rst)
    wake_req == (st_q && en_q));
  // R9: function-level reset keeps the wake pair
  a_r9_pair_kept: assert property (@(posedge clk) disable iff (rst)
    (flr && !wake_off && !wake_evt) |=> (en_q == $past(en_q) && st_q == $past(st_q)));
endmodule

// File: tb/pmcs_unit_tb.sv
`timescale 1ns/1ps
module pmcs_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, flr, cfg_wr, cfg_rd, wake_evt;
  logic [7:0]  class_mode, cfg_addr;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        wake_req, io_dec_en, mem_dec_en, irq_en;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pmcs_unit dut_i (
    .clk(clk), .rst(rst), .flr(flr), .class_mode(class_mode),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wake_evt(wake_evt),
    .wake_req(wake_req), .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en), .irq_en(irq_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    d = cfg_rdata; cfg_rd = 1'b0;
  endtask

  task automatic evt();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic gates(input string tag, input logic exp);
    chk(tag, {13'd0, io_dec_en, mem_dec_en, irq_en}, {13'd0, {3{exp}}});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    rd(8'h74, d);
    chk("R1 reset value", d, 16'h0008);
    gates("R1 reset gates", 1'b1);
    chk("R1 reset wake_req", {15'd0, wake_req}, 16'h0);
    @(negedge clk);
    chk("R13 idle rdata", cfg_rdata, 16'h0);
  endtask

  task automatic t_pstate();
    logic [15:0] d;
    wr(8'h74, 2'b11, 16'h0003);
    gates("R11 D3 gates", 1'b0);
    rd(8'h74, d);
    chk("R2/R11 D3 read", d, 16'h000B);
    wr(8'h74, 2'b11, 16'h0001);
    rd(8'h74, d);
    chk("R2 code 01 ignored", d, 16'h000B);
    wr(8'h74, 2'b11, 16'h0002);
    rd(8'h74, d);
    chk("R2 code 10 ignored", d, 16'h000B);
    wr(8'h74, 2'b11, 16'h0000);
    gates("R11 D0 gates", 1'b1);
    rd(8'h74, d);
    chk("R2 back to D0", d, 16'h0008);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(8'h74, 2'b11, 16'hFFFF);
    rd(8'h74, d);
    chk("R3/R4 all-ones write", d, 16'h010B);
    wr(8'h74, 2'b11, 16'h0000);
    rd(8'h74, d);
    chk("R3/R4 zero write", d, 16'h0008);
  endtask

  task automatic t_lanes();
    logic [15:0] d;
    wr(8'h74, 2'b01, 16'h0103);
    rd(8'h74, d);
    chk("R12 low lane only", d, 16'h000B);
    wr(8'h74, 2'b10, 16'h0100);
    rd(8'h74, d);
    chk("R12 high lane only", d, 16'h010B);
    wr(8'h70, 2'b11, 16'h8000);
    rd(8'h74, d);
    chk("R12 foreign write", d, 16'h010B);
    rd(8'h70, d);
    chk("R12 foreign read", d, 16'h0000);
    wr(8'h74, 2'b11, 16'h0000);
  endtask

  task automatic t_wake();
    logic [15:0] d;
    wr(8'h74, 2'b11, 16'h0100);
    evt();
    chk("R7 request on", {15'd0, wake_req}, 16'h1);
    rd(8'h74, d);
    chk("R5 status set", d, 16'h8108);
    wr(8'h74, 2'b11, 16'h0100);
    rd(8'h74, d);
    chk("R5 write 0 keeps", d, 16'h8108);
    wr(8'h74, 2'b11, 16'h8100);
    chk("R7 request off", {15'd0, wake_req}, 16'h0);
    rd(8'h74, d);
    chk("R5 w1c", d, 16'h0108);
    wr(8'h74, 2'b11, 16'h0000);
    evt();
    chk("R7 no enable no request", {15'd0, wake_req}, 16'h0);
    @(negedge clk);
    cfg_addr = 8'h74; cfg_be = 2'b11; cfg_wdata = 16'h8000; cfg_wr = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; wake_evt = 1'b0;
    rd(8'h74, d);
    chk("R6 event beats clear", d, 16'h8008);
    wr(8'h74, 2'b11, 16'h8000);
  endtask

  task automatic t_flr();
    logic [15:0] d;
    wr(8'h74, 2'b11, 16'h0103);
    evt();
    @(negedge clk);
    flr = 1'b1; cfg_addr = 8'h74; cfg_be = 2'b11; cfg_wdata = 16'h8003; cfg_wr = 1'b1;
    @(negedge clk);
    flr = 1'b0; cfg_wr = 1'b0;
    gates("R9 flr gates", 1'b1);
    rd(8'h74, d);
    chk("R9 flr keeps wake", d, 16'h8108);
    chk("R9 flr request kept", {15'd0, wake_req}, 16'h1);
    wr(8'h74, 2'b11, 16'h0003);
    do_reset();
    gates("R10 rst gates", 1'b1);
    chk("R10 rst request", {15'd0, wake_req}, 16'h0);
    rd(8'h74, d);
    chk("R10 rst clears all", d, 16'h0008);
  endtask

  task automatic t_mode();
    logic [15:0] d;
    wr(8'h74, 2'b11, 16'h0100);
    evt();
    @(negedge clk); class_mode = 8'h01;
    @(negedge clk);
    chk("R8 request forced off", {15'd0, wake_req}, 16'h0);
    rd(8'h74, d);
    chk("R8 bits read 0", d, 16'h0008);
    wr(8'h74, 2'b11, 16'h0100);
    evt();
    rd(8'h74, d);
    chk("R8 write/event ignored", d, 16'h0008);
    @(negedge clk); class_mode = 8'h06;
    rd(8'h74, d);
    chk("R8 mode exit stays 0", d, 16'h0008);
    wr(8'h74, 2'b11, 16'h0100);
    rd(8'h74, d);
    chk("R4 enable writable again", d, 16'h0108);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flr = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0; wake_evt = 1'b0;
    class_mode = 8'h06; cfg_addr = 8'h00; cfg_be = 2'b00; cfg_wdata = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    t_pstate();
    t_reserved();
    t_lanes();
    t_wake();
    t_flr();
    t_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule